// File: doc/BRIEF.md
# Select-Addressed Clock Divider and Output Enable Bank

This block forms the digital back end of a multi-output clock generator. Upstream frequency synthesis delivers a small set of source clocks. Each one reaches the block as a one-cycle tick qualifier in the `clk_i` domain. The block turns them into nine output clocks.

A 3-bit select input picks one of eight built-in configurations. A configuration sets three things:
- which source feeds each of three dividers;
- the ratio of each divider;
- which outputs are enabled.

Outputs 0 to 3 form one bank on a shared divider, and outputs 4 to 7 form a second bank on another divider. Output 8 has its own divider.

An active-low power-down input disables every output, reported as output-enable low and data low, and holds the dividers idle. Raising power-down, or changing the select while powered, starts a clean restart. On a restart all dividers begin from phase zero together. Output 6 then carries a fixed test pattern for 170 cycles. Both select and power-down pass through two synchronizing flops before the block uses them. `rst_ni` is asserted asynchronously and must be released synchronously to `clk_i`.

Top module: `clkdiv_bank`

## Requirements
- R1: A divider of ratio N (2 to 20) and a source that ticks every T cycles gives an output that is high for ((N+1)/2)·T cycles and low for floor(N/2)·T cycles, repeating. Odd ratios are high for the longer half.
- R2: The select value e (0 to 7) picks the following settings:
  - Bank 0 (outputs 0 to 3): ratio 2+e, on source bit e[0].
  - Bank 1 (outputs 4 to 7): ratio 20−2e, on source 0.
  - Output 8: ratio 3+2e, on source bit e[1].
- R3: All enabled outputs of one bank show the same value in every cycle. The exception is output 6 while its test window is active.
- R4: While the synchronized power-down input is low, every output-enable bit and every output data bit is 0. This includes the time during reset.
- R5: After power-down goes high, output 6 alternates low and high every cycle for 170 cycles, starting low. That window contains 84 or 85 isolated one-cycle high pulses; the last pulse may merge with the bank output that follows.
- R6: A change of the synchronized select while powered restarts all dividers and runs the 170-cycle test window again. With no change, no test window appears.
- R7: Each output has an enable bit in the configuration. Entry 5 disables outputs 1 and 5, whose enable and data then stay 0. All other entries enable all nine outputs.
- R8: The two banks may take the same source with different ratios. Entry 0 feeds both from source 0, with ratios 2 and 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all sources are ticks in this domain |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_ni | input | 1 | Active-low power-down / output disable (asynchronous) |
| sel_i | input | 3 | Configuration select (asynchronous) |
| src_tick_i | input | 2 | One-cycle tick of each synthesized source |
| clk_o | output | 9 | Divided output clocks (0 when disabled) |
| oe_o | output | 9 | Output enable per pin; 0 means high impedance at the pad |

## Verification
The bench runs the dividers under two source patterns: a tick every cycle and a tick every other cycle. Four configurations are used, so even and odd ratios, and ratios at both ends of the range, are measured by their high and low lengths. This separates a wrong ratio, a wrong duty split and a wrong source choice. Two cases check the restart behaviour:
- A select change and a power-up are each followed by a count of isolated one-cycle pulses on output 6.
- A stretch with no change must show no such pulses.

Power-down, the enable mask of entry 5, and cycle-by-cycle equality within each bank are each checked at the pins.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NOUT     = 9;
  localparam int NGRP     = 3;
  localparam int BANK_SZ  = 4;
  localparam int DIV_W    = 5;
  localparam int DIV_MIN  = 2;
  localparam int DIV_MAX  = 20;
  localparam int SRC_N    = 2;
  localparam int SRC_W    = $clog2(SRC_N);
  localparam int SEL_W    = 3;
  localparam int TEST_IDX = 6;

  typedef struct packed {
    logic [NGRP-1:0][DIV_W-1:0] div;
    logic [NGRP-1:0][SRC_W-1:0] src;
    logic [NOUT-1:0]            en;
  } cfg_t;

  // Divider group driving a given output pin.
  function automatic int grp_of(input int idx);
    if (idx < BANK_SZ)       return 0;
    else if (idx < 2*BANK_SZ) return 1;
    else                     return 2;
  endfunction

  // Constant configuration store, computed from the entry number.
  function automatic cfg_t cfg_lookup(input logic [SEL_W-1:0] e);
    cfg_t c;
    c.div[0] = DIV_W'(2 + int'(e));
    c.div[1] = DIV_W'(20 - 2*int'(e));
    c.div[2] = DIV_W'(3 + 2*int'(e));
    c.src[0] = SRC_W'(e[0]);
    c.src[1] = '0;
    c.src[2] = SRC_W'(e[1]);
    c.en     = '1;
    if (e == SEL_W'(5)) begin
      c.en[1] = 1'b0;
      c.en[5] = 1'b0;
    end
    return c;
  endfunction
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
  parameter int SEL_W    = 3,
  parameter int TEST_CYC = 170
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic             clr_o,
  output logic             win_o,
  output logic             tpat_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int CNT_W = $clog2(TEST_CYC + 1);

  logic             pd_s, pd_q;
  logic [SEL_W-1:0] sel_s, cur_sel_q, cur_sel_d;
  logic [CNT_W-1:0] test_cnt_q, test_cnt_d;
  logic             tpat_q, tpat_d;
  logic             restart;

  clkdiv_sync #(.W(1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_ni), .q_o(pd_s)
  );
  clkdiv_sync #(.W(SEL_W)) u_sel_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_i), .q_o(sel_s)
  );

  assign restart = pd_s && (!pd_q || (sel_s != cur_sel_q));

  always_comb begin
    cur_sel_d  = cur_sel_q;
    test_cnt_d = test_cnt_q;
    tpat_d     = tpat_q;
    if (!pd_s) begin
      test_cnt_d = '0;
      tpat_d     = 1'b0;
    end else if (restart) begin
      cur_sel_d  = sel_s;
      test_cnt_d = CNT_W'(TEST_CYC);
      tpat_d     = 1'b0;
    end else if (test_cnt_q != '0) begin
      test_cnt_d = test_cnt_q - 1'b1;
      tpat_d     = !tpat_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q       <= 1'b0;
      cur_sel_q  <= '0;
      test_cnt_q <= '0;
      tpat_q     <= 1'b0;
    end else begin
      pd_q       <= pd_s;
      cur_sel_q  <= cur_sel_d;
      test_cnt_q <= test_cnt_d;
      tpat_q     <= tpat_d;
    end
  end

  assign run_o  = pd_s;
  assign clr_o  = restart || !pd_s;
  assign win_o  = (test_cnt_q != '0);
  assign tpat_o = tpat_q;
  assign sel_o  = cur_sel_q;

  // R5
  win_len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_cnt_q <= CNT_W'(TEST_CYC));

  // R6
  sel_swap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_sel_q) |-> test_cnt_q == CNT_W'(TEST_CYC));

  // R5
  pd_rise_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> win_o);
endmodule

// File: rtl/clkdiv_div.sv
module clkdiv_div #(
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             q_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             q_q, q_d;
  logic [DIV_W:0]   hi_len;

  assign hi_len = ({1'b0, div_i} + 1'b1) >> 1;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (clr_i) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == div_i - 1'b1) ? '0 : cnt_q + 1'b1;
      q_d   = ({1'b0, cnt_q} < hi_len);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q_o = q_q;

  // R1
  ratio_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_i >= DIV_W'(DIV_MIN) && div_i <= DIV_W'(DIV_MAX));

  // R1
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_i);

  // R1
  rise_at_phase1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> cnt_q == DIV_W'(1));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int TEST_CYC = 170
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SRC_N-1:0] src_tick_i,
  output logic [NOUT-1:0]  clk_o,
  output logic [NOUT-1:0]  oe_o
);
  logic             run, clr, win, tpat;
  logic [SEL_W-1:0] cur_sel;
  cfg_t             cfg;
  logic [NGRP-1:0]  grp_q;

  clkdiv_ctrl #(.SEL_W(SEL_W), .TEST_CYC(TEST_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .sel_i(sel_i),
    .run_o(run), .clr_o(clr), .win_o(win), .tpat_o(tpat), .sel_o(cur_sel)
  );

  assign cfg = cfg_lookup(cur_sel);

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    clkdiv_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .tick_i(src_tick_i[cfg.src[g]]), .div_i(cfg.div[g]), .q_o(grp_q[g])
    );
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int G = grp_of(i);
    logic raw;
    if (i == TEST_IDX) begin : g_tst
      assign raw = win ? tpat : grp_q[G];
    end else begin : g_nrm
      assign raw = grp_q[G];
    end
    assign oe_o[i]  = run && cfg.en[i];
    assign clk_o[i] = raw && oe_o[i];
  end

  // R4
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pd_ni, 2) |-> (oe_o == '0 && clk_o == '0));
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  logic       clk = 1'b0;
  logic       rst_n, pd_n;
  logic [2:0] sel;
  logic [1:0] tick;
  logic [8:0] clk_o, oe_o;
  int total = 0, bad = 0;
  bit busy = 1'b0;

  typedef struct { int idx; int hi; int lo; string req; } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  clkdiv_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .sel_i(sel),
    .src_tick_i(tick), .clk_o(clk_o), .oe_o(oe_o)
  );

  // source 0 ticks every cycle, source 1 every other cycle
  initial begin
    tick = 2'b01;
    forever begin
      @(negedge clk);
      tick[1] = ~tick[1];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_ratio(input int e, input int g);
    if (g == 0) return 2 + e;
    if (g == 1) return 20 - 2*e;
    return 3 + 2*e;
  endfunction

  function automatic int ref_period(input int e, input int g);
    if (g == 0) return (e % 2 == 1) ? 2 : 1;
    if (g == 1) return 1;
    return ((e / 2) % 2 == 1) ? 2 : 1;
  endfunction

  task automatic push_exp(input int e, input int idx, input string req);
    exp_t it;
    int g, n, t;
    g = (idx < 4) ? 0 : ((idx < 8) ? 1 : 2);
    n = ref_ratio(e, g);
    t = ref_period(e, g);
    it.idx = idx;
    it.hi  = ((n + 1) / 2) * t;
    it.lo  = (n / 2) * t;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic measure(input int idx, output int h, output int l);
    int guard = 0;
    while (clk_o[idx] !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
    while (clk_o[idx] !== 1'b1 && guard < 800) begin @(negedge clk); guard++; end
    h = 0;
    while (clk_o[idx] === 1'b1 && h < 400) begin @(negedge clk); h++; end
    l = 0;
    while (clk_o[idx] === 1'b0 && l < 400) begin @(negedge clk); l++; end
  endtask

  // monitor: pops expected items and compares measured waveforms
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t it;
        int h, l;
        busy = 1'b1;
        it = sbq.pop_front();
        measure(it.idx, h, l);
        chk(h == it.hi, it.req, $sformatf("high length out%0d", it.idx), h, it.hi);
        chk(l == it.lo, it.req, $sformatf("low length out%0d", it.idx), l, it.lo);
        busy = 1'b0;
      end
    end
  end

  task automatic drain();
    while (sbq.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int p);
    logic a, b, c;
    p = 0;
    a = clk_o[6];
    b = a;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c = clk_o[6];
      if (a == 1'b0 && b == 1'b1 && c == 1'b0) p++;
      a = b;
      b = c;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, errs;
    rst_n = 1'b0; pd_n = 1'b0; sel = 3'd0;
    repeat (5) @(negedge clk);
    chk(oe_o == 9'h000 && clk_o == 9'h000, "R4", "outputs in reset", int'(oe_o | clk_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(oe_o == 9'h000, "R4", "oe while powered down", int'(oe_o), 0);

    // power up, entry 0
    pd_n = 1'b1;
    count_pulses(260, p);
    chk(p >= 84 && p <= 85, "R5", "test pulses after power-up", p, 85);
    chk(oe_o == 9'h1FF, "R7", "all enables entry 0", int'(oe_o), 'h1FF);
    push_exp(0, 0, "R1");
    push_exp(0, 4, "R8");
    push_exp(0, 8, "R1");
    drain();

    errs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (clk_o[0] !== clk_o[3] || clk_o[4] !== clk_o[7] || clk_o[5] !== clk_o[6]) errs++;
    end
    chk(errs == 0, "R3", "bank members differ", errs, 0);

    count_pulses(100, p);
    chk(p == 0, "R6", "no test window without change", p, 0);

    // select change to entry 3
    sel = 3'd3;
    count_pulses(260, p);
    chk(p >= 84 && p <= 85, "R6", "test pulses after select change", p, 85);
    push_exp(3, 0, "R2");
    push_exp(3, 4, "R2");
    push_exp(3, 8, "R2");
    drain();

    // entry 5: enable mask
    sel = 3'd5;
    count_pulses(260, p);
    errs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (oe_o[1] !== 1'b0 || oe_o[5] !== 1'b0 || clk_o[1] !== 1'b0 || clk_o[5] !== 1'b0) errs++;
      if ((oe_o & 9'h1DD) !== 9'h1DD) errs++;
    end
    chk(errs == 0, "R7", "masked outputs entry 5", errs, 0);
    push_exp(5, 0, "R2");
    push_exp(5, 8, "R2");
    drain();

    // entry 7
    sel = 3'd7;
    count_pulses(260, p);
    push_exp(7, 3, "R1");
    push_exp(7, 7, "R1");
    push_exp(7, 8, "R1");
    drain();

    // power down
    pd_n = 1'b0;
    repeat (4) @(negedge clk);
    errs = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (oe_o !== 9'h000 || clk_o !== 9'h000) errs++;
    end
    chk(errs == 0, "R4", "outputs during power-down", errs, 0);

    pd_n = 1'b1;
    count_pulses(260, p);
    chk(p >= 84 && p <= 85, "R5", "test pulses after re-power", p, 85);
    push_exp(7, 4, "R1");
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule